// File: doc/BRIEF.md
# Grouped Priority Interrupt Encoder

The block collects raw interrupt requests from three groups: three critical sources, seventeen main sources and twenty-two peripheral sources. Peripheral source 0 carries the combined request of a set of DMA tasks. Each clock, it works out the winning source of each group. It publishes all three winners in one 32-bit status word, and each group's field has its own pending flag. Software reads that word once and services the first group whose flag is set, in the order critical, then main, then peripheral.

Main sources and peripheral sources 1 to 21 can be disabled through two mask registers. Critical sources and peripheral source 0 cannot be masked. Each peripheral source also carries a 2-bit boost setting. A source boosted to high is announced in the critical field with a reserved code. A source boosted to medium is announced in the main field with a reserved code. In both cases the peripheral field names the actual source. A single interrupt line is raised whenever any field is pending.

Top module: `grp_irq_encoder`

## Requirements
- R1: The status word is registered, so it reflects the inputs one clock later. Bit 10 is the critical pending flag and bits [9:8] are the critical code. Bit 21 is the main pending flag and bits [20:16] are the main code. Bit 29 is the peripheral pending flag and bits [28:24] are the peripheral code. All other bits are zero, and a field's code is zero while its flag is clear.
- R2: Critical sources 0, 1 and 2 report codes 0, 1 and 3. Code 2 means that an enabled peripheral boosted to high is pending. When several are pending, the lowest code wins. Critical sources cannot be masked.
- R3: Main source n reports code n. Among the enabled pending main sources, the lowest-numbered one wins. Main mask bit 16-n set to 1 disables source n. The main_req[4] input has no effect.
- R4: Main code 4 is reported when an enabled peripheral boosted to medium is pending and main mask bit 12 is 0. Setting that bit removes code 4 from the main field but leaves the peripheral field unchanged.
- R5: Peripheral mask bit 31-n set to 1 disables peripheral source n, for n from 1 to 21. Peripheral source 0 is always enabled, and mask bit 31 has no effect.
- R6: The peripheral field reports the lowest-numbered enabled pending source in the highest boost class present. The classes rank high first, then medium, then normal.
- R7: The boost setting of peripheral n is boost_wdata[2n+1:2n]. A value of 1 means medium, 2 means high, and 0 or 3 means normal.
- R8: The irq output is high exactly when at least one of the three pending flags in the current status word is set.
- R9: On reset, both mask registers are all ones, all boost settings are normal, and status and irq are zero.
- R10: A mask or boost write is captured on the clock edge where its write enable is high. The status word reflects the new setting one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crit_req | input | 3 | Critical group requests |
| main_req | input | 17 | Main group requests |
| per_req | input | 22 | Peripheral group requests; bit 0 is the DMA aggregate |
| main_mask_we | input | 1 | Main mask write enable |
| main_mask_wdata | input | 17 | Main mask value; bit 16-n disables source n |
| per_mask_we | input | 1 | Peripheral mask write enable |
| per_mask_wdata | input | 32 | Peripheral mask value; bit 31-n disables source n |
| boost_we | input | 1 | Boost write enable |
| boost_wdata | input | 44 | Two boost bits per peripheral source |
| status | output | 32 | Encoded status word |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a single peripheral appearing in two fields at once. A boosted source must show up both through the reserved code of a higher field and by its own number in the peripheral field. This has to happen while raw critical or main sources compete for the same fields, and while main mask bit 12 independently suppresses the medium slot. The stimulus gets there in stages. It first unmasks the groups through the register writes. It then changes the boost of one peripheral between high, medium and the reserved value 3. At each step it adds competing critical and main requests, so that both the winning codes and the redirected peripheral number are observed.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
    localparam int STAT_W   = 32;
    localparam int CODE_W   = 5;
    localparam int CRIT_N   = 3;
    localparam int MAIN_N   = 17;
    localparam int PER_N    = 22;
    localparam int BOOST_W  = 2 * PER_N;
    localparam int MAIN_BOOST_SLOT = 4;

    typedef enum logic [1:0] {
        BOOST_NORMAL = 2'd0,
        BOOST_MEDIUM = 2'd1,
        BOOST_HIGH   = 2'd2,
        BOOST_SPARE  = 2'd3
    } boost_e;

    typedef struct packed {
        logic              pend;
        logic [CODE_W-1:0] code;
    } field_t;

    function automatic logic [STAT_W-1:0] pack_status(field_t c, field_t m, field_t p);
        logic [STAT_W-1:0] w;
        w = '0;
        w[10]    = c.pend;
        w[9:8]   = c.pend ? c.code[1:0] : 2'd0;
        w[21]    = m.pend;
        w[20:16] = m.pend ? m.code : '0;
        w[29]    = p.pend;
        w[28:24] = p.pend ? p.code : '0;
        return w;
    endfunction
endpackage

// File: rtl/grp_irq_prienc.sv
module grp_irq_prienc
    import grp_irq_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] vec,
    output field_t       fld
);
    always_comb begin
        fld = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                fld.pend = 1'b1;
                fld.code = CODE_W'(i);
            end
        end
    end
endmodule

// File: rtl/grp_irq_regs.sv
module grp_irq_regs
    import grp_irq_pkg::*;
#(
    parameter int MN = MAIN_N,
    parameter int BW = BOOST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              main_we,
    input  logic [MN-1:0]     main_wdata,
    input  logic              per_we,
    input  logic [STAT_W-1:0] per_wdata,
    input  logic              boost_we,
    input  logic [BW-1:0]     boost_wdata,
    output logic [MN-1:0]     main_mask,
    output logic [STAT_W-1:0] per_mask,
    output logic [BW-1:0]     boost
);
    always_ff @(posedge clk) begin
        if (rst) begin
            main_mask <= '1;
            per_mask  <= '1;
            boost     <= '0;
        end else begin
            if (main_we)  main_mask <= main_wdata;
            if (per_we)   per_mask  <= per_wdata;
            if (boost_we) boost     <= boost_wdata;
        end
    end
endmodule

// File: rtl/grp_irq_sort.sv
module grp_irq_sort
    import grp_irq_pkg::*;
#(
    parameter int PN = PER_N
) (
    input  logic [PN-1:0]     per_req,
    input  logic [STAT_W-1:0] per_mask,
    input  logic [2*PN-1:0]   boost,
    output logic [PN-1:0]     cls_norm,
    output logic [PN-1:0]     cls_med,
    output logic [PN-1:0]     cls_high
);
    logic [PN-1:0] live;

    for (genvar n = 0; n < PN; n++) begin : g_src
        if (n == 0) begin : g_always_on
            assign live[n] = per_req[n];
        end else begin : g_masked
            assign live[n] = per_req[n] & ~per_mask[STAT_W-1-n];
        end
        boost_e lvl;
        assign lvl         = boost_e'(boost[2*n +: 2]);
        assign cls_high[n] = live[n] & (lvl == BOOST_HIGH);
        assign cls_med[n]  = live[n] & (lvl == BOOST_MEDIUM);
        assign cls_norm[n] = live[n] & (lvl == BOOST_NORMAL || lvl == BOOST_SPARE);
    end

    logic unused_mask_bits;
    assign unused_mask_bits = ^{per_mask[STAT_W-1], per_mask[STAT_W-PN-1:0]};
endmodule

// File: rtl/grp_irq_encoder.sv
module grp_irq_encoder
    import grp_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CRIT_N-1:0]  crit_req,
    input  logic [MAIN_N-1:0]  main_req,
    input  logic [PER_N-1:0]   per_req,
    input  logic               main_mask_we,
    input  logic [MAIN_N-1:0]  main_mask_wdata,
    input  logic               per_mask_we,
    input  logic [STAT_W-1:0]  per_mask_wdata,
    input  logic               boost_we,
    input  logic [BOOST_W-1:0] boost_wdata,
    output logic [STAT_W-1:0]  status,
    output logic               irq
);
    logic [MAIN_N-1:0]  main_mask;
    logic [STAT_W-1:0]  per_mask;
    logic [BOOST_W-1:0] boost;
    logic [PER_N-1:0]   cls_norm, cls_med, cls_high;

    grp_irq_regs #(.MN(MAIN_N), .BW(BOOST_W)) i_regs (
        .clk(clk), .rst(rst),
        .main_we(main_mask_we), .main_wdata(main_mask_wdata),
        .per_we(per_mask_we), .per_wdata(per_mask_wdata),
        .boost_we(boost_we), .boost_wdata(boost_wdata),
        .main_mask(main_mask), .per_mask(per_mask), .boost(boost)
    );

    grp_irq_sort #(.PN(PER_N)) i_sort (
        .per_req(per_req), .per_mask(per_mask), .boost(boost),
        .cls_norm(cls_norm), .cls_med(cls_med), .cls_high(cls_high)
    );

    // Critical field: codes 0,1 raw, 2 boosted-high peripheral, 3 raw source 2
    logic [3:0] crit_vec;
    assign crit_vec = {crit_req[2], |cls_high, crit_req[1:0]};

    // Main field: slot 4 is the medium-boost redirection
    logic [MAIN_N-1:0] main_vec;
    for (genvar n = 0; n < MAIN_N; n++) begin : g_main
        if (n == MAIN_BOOST_SLOT) begin : g_slot
            assign main_vec[n] = (|cls_med) & ~main_mask[MAIN_N-1-n];
        end else begin : g_raw
            assign main_vec[n] = main_req[n] & ~main_mask[MAIN_N-1-n];
        end
    end

    // Peripheral field: highest boost class present selects the candidates
    logic [PER_N-1:0] per_vec;
    always_comb begin
        if (|cls_high)     per_vec = cls_high;
        else if (|cls_med) per_vec = cls_med;
        else               per_vec = cls_norm;
    end

    field_t f_crit, f_main, f_per;
    grp_irq_prienc #(.W(4))      i_enc_crit (.vec(crit_vec), .fld(f_crit));
    grp_irq_prienc #(.W(MAIN_N)) i_enc_main (.vec(main_vec), .fld(f_main));
    grp_irq_prienc #(.W(PER_N))  i_enc_per  (.vec(per_vec),  .fld(f_per));

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= pack_status(f_crit, f_main, f_per);
            irq    <= f_crit.pend | f_main.pend | f_per.pend;
        end
    end

    logic unused_main_slot;
    assign unused_main_slot = main_req[MAIN_BOOST_SLOT];
endmodule

// File: rtl/grp_irq_encoder_chk.sv
module grp_irq_encoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  crit_req,
    input logic [31:0] status,
    input logic        irq
);
    p_irq_flags_r8: assert property (@(posedge clk) disable iff (rst)
        irq == (status[10] | status[21] | status[29]));

    p_idle_codes_r1: assert property (@(posedge clk) disable iff (rst)
        (!status[10] -> status[9:8] == 2'd0) &&
        (!status[21] -> status[20:16] == 5'd0) &&
        (!status[29] -> status[28:24] == 5'd0));

    p_spare_bits_r1: assert property (@(posedge clk) disable iff (rst)
        status[31:30] == 2'd0 && status[23:22] == 2'd0 &&
        status[15:11] == 5'd0 && status[7:0] == 8'd0);

    p_crit_redirect_r2: assert property (@(posedge clk) disable iff (rst)
        (status[10] && status[9:8] == 2'd2) |-> status[29]);

    p_crit_unmaskable_r2: assert property (@(posedge clk) disable iff (rst)
        (|crit_req) |=> status[10]);

    p_main_range_r3: assert property (@(posedge clk) disable iff (rst)
        status[21] |-> status[20:16] <= 5'd16);

    p_main_redirect_r4: assert property (@(posedge clk) disable iff (rst)
        (status[21] && status[20:16] == 5'd4) |-> status[29]);
endmodule

bind grp_irq_encoder grp_irq_encoder_chk i_chk (
    .clk(clk), .rst(rst), .crit_req(crit_req), .status(status), .irq(irq)
);

// File: tb/test_grp_irq_encoder.sv
module test_grp_irq_encoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  crit_req = '0;
    logic [16:0] main_req = '0;
    logic [21:0] per_req = '0;
    logic        main_mask_we = 1'b0;
    logic [16:0] main_mask_wdata = '0;
    logic        per_mask_we = 1'b0;
    logic [31:0] per_mask_wdata = '0;
    logic        boost_we = 1'b0;
    logic [43:0] boost_wdata = '0;
    logic [31:0] status;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_irq_encoder i_grp_irq_encoder (.*);

    // bench copies of the programmed settings (R9 reset values)
    logic [16:0] m_mask = '1;
    logic [31:0] p_mask = '1;
    logic [43:0] m_boost = '0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [32:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    event  pushed;

    function automatic logic [32:0] model();
        logic [21:0] hi, med, nrm, sel;
        logic [3:0]  cv;
        logic [16:0] mv;
        logic        cp, mp, pp;
        logic [4:0]  cc, mc, pc;
        logic [31:0] w;
        for (int n = 0; n < 22; n++) begin
            logic a;
            logic [1:0] b;
            a = per_req[n] && (n == 0 || !p_mask[31-n]);
            b = m_boost[2*n +: 2];
            hi[n]  = a && b == 2'd2;
            med[n] = a && b == 2'd1;
            nrm[n] = a && (b == 2'd0 || b == 2'd3);
        end
        cv = {crit_req[2], |hi, crit_req[1:0]};
        for (int n = 0; n < 17; n++)
            mv[n] = (n == 4) ? ((|med) && !m_mask[12]) : (main_req[n] && !m_mask[16-n]);
        sel = (|hi) ? hi : ((|med) ? med : nrm);
        cp = 0; mp = 0; pp = 0; cc = 0; mc = 0; pc = 0;
        for (int n = 3; n >= 0; n--)  if (cv[n])  begin cp = 1; cc = 5'(n); end
        for (int n = 16; n >= 0; n--) if (mv[n])  begin mp = 1; mc = 5'(n); end
        for (int n = 21; n >= 0; n--) if (sel[n]) begin pp = 1; pc = 5'(n); end
        w = '0;
        w[10] = cp; w[9:8] = cc[1:0];
        w[21] = mp; w[20:16] = mc;
        w[29] = pp; w[28:24] = pc;
        return {cp | mp | pp, w};
    endfunction

    // driver side: let the inputs settle through the registers, then push
    task automatic expect_now(input string tag);
        item_t it;
        @(negedge clk);
        @(negedge clk);
        it.exp = model();
        it.tag = tag;
        sb.push_back(it);
        ->pushed;
        #1;
    endtask

    // monitor side
    initial begin
        forever begin
            @(pushed);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if ({irq, status} !== it.exp) begin
                    errors++;
                    $display("FAIL %s: irq/status actual %0b/%h expected %0b/%h",
                             it.tag, irq, status, it.exp[32], it.exp[31:0]);
                end
            end
        end
    end

    task automatic wr_main(input logic [16:0] v);
        @(negedge clk); main_mask_wdata = v; main_mask_we = 1'b1; m_mask = v;
        @(negedge clk); main_mask_we = 1'b0;
    endtask
    task automatic wr_per(input logic [31:0] v);
        @(negedge clk); per_mask_wdata = v; per_mask_we = 1'b1; p_mask = v;
        @(negedge clk); per_mask_we = 1'b0;
    endtask
    task automatic wr_boost(input logic [43:0] v);
        @(negedge clk); boost_wdata = v; boost_we = 1'b1; m_boost = v;
        @(negedge clk); boost_we = 1'b0;
    endtask
    task automatic reqs(input logic [2:0] c, input logic [16:0] m, input logic [21:0] p);
        @(negedge clk); crit_req = c; main_req = m; per_req = p;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state while reset is held
        checks++;
        if (status !== 32'd0 || irq !== 1'b0) begin
            errors++;
            $display("FAIL R9 in reset: actual %h/%0b expected 0/0", status, irq);
        end
        rst = 1'b0;
        // R9: masks reset to all ones, so masked requests stay silent
        reqs(3'b000, 17'h1FFFF, 22'h3FFFFE);
        expect_now("R9 masks reset to all ones");
        // R5: peripheral 0 always enabled
        reqs(3'b000, 17'h1FFFF, 22'h3FFFFF);
        expect_now("R5 source 0 unmaskable");
        // R2 critical codes and order
        reqs(3'b100, 17'h0, 22'h0);
        expect_now("R2 critical source 2 code 3");
        reqs(3'b110, 17'h0, 22'h0);
        expect_now("R2 critical lowest wins");
        reqs(3'b001, 17'h0, 22'h1);
        expect_now("R1 R2 critical with peripheral field");
        // R3 main priority, ignored input 4, R10 write timing
        wr_main(17'h0);
        reqs(3'b000, 17'h00090, 22'h0);
        expect_now("R3 R10 main_req 4 ignored, code 7");
        reqs(3'b000, 17'h00084, 22'h0);
        expect_now("R3 main lowest wins");
        wr_main(17'h04000);
        expect_now("R3 main mask bit 14 disables source 2");
        // R5 peripheral masking
        wr_per(32'h0);
        reqs(3'b000, 17'h0, 22'h000208);
        expect_now("R5 peripheral unmasked lowest wins");
        wr_per(32'h10000000);
        expect_now("R5 mask bit 28 disables source 3");
        wr_per(32'h80000000);
        reqs(3'b000, 17'h0, 22'h000001);
        expect_now("R5 mask bit 31 no effect");
        // R6 R7 boost high on source 9
        wr_per(32'h0);
        wr_boost(44'h0 | (44'd2 << 18));
        reqs(3'b000, 17'h0, 22'h000208);
        expect_now("R6 R7 boosted high redirects critical code 2");
        reqs(3'b001, 17'h0, 22'h000208);
        expect_now("R2 raw critical 0 beats redirect");
        // R4 medium boost
        wr_boost(44'h0 | (44'd1 << 18));
        reqs(3'b000, 17'h0, 22'h000208);
        expect_now("R4 medium boost main code 4");
        reqs(3'b000, 17'h00004 | 17'h00080, 22'h000208);
        expect_now("R4 raw main 7 with slot 4 lowest wins");
        wr_main(17'h01000);
        expect_now("R4 main mask bit 12 hides slot");
        // R7 spare boost value behaves as normal
        wr_boost(44'h0 | (44'd3 << 18));
        reqs(3'b000, 17'h0, 22'h000208);
        expect_now("R7 boost 3 is normal");
        // R8 idle
        reqs(3'b000, 17'h0, 22'h0);
        expect_now("R8 irq low when idle");
        reqs(3'b000, 17'h00100, 22'h0);
        expect_now("R8 irq from main only");
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule